// File: doc/BRIEF.md
# Bus Width Splitter

This block sits between a requester that issues 8-, 16- or 32-bit accesses and an external bus sequencer that only moves 8 or 16 bits per cycle. Every accepted access is cut into the right number of narrow sub-cycles. Each sub-cycle carries a bus-unit address derived from the byte address, a byte-lane mask, the write data for that piece, and a flag that tells the sequencer whether chip select must stay asserted into the next sub-cycle.

On reads, the pieces that come back are packed into one little-endian word, and that word is returned with a single completion pulse. The width of the external bus is a configuration input that is captured when an access is accepted. Strobe timing is left to the sequencer.

Top module: `bus_width_splitter`

## Requirements
- R1: After reset `cpu_ready` is 1, and `sub_req` and `cpu_done` are 0.
- R2: Sizes are encoded on `cpu_size` as 0 = byte, 1 = halfword, 2 = word. With `bus_wide` = 0 (8-bit bus), a byte, halfword or word access issues 1, 2 or 4 sub-cycles. With `bus_wide` = 1 (16-bit bus), it issues 1, 1 or 2 sub-cycles.
- R3: Sub-cycles go out lowest address first. `sub_addr` is the byte address on an 8-bit bus and the byte address shifted right by one on a 16-bit bus. Each following sub-cycle of the same access has a `sub_addr` one higher than the previous one. Halfword and word addresses are naturally aligned.
- R4: On a write, `sub_hold_cs` is 1 on every sub-cycle except the last, where it is 0.
- R5: On a read, `sub_hold_cs` is 0 on every sub-cycle.
- R6: Read pieces are packed little-endian into `cpu_rdata`. The piece from the lowest address goes in the least significant bits, and the bits above the access size are zero.
- R7: Lanes and data placement:
  - On an 8-bit bus, `sub_lane` is 01, write data sits in `sub_wdata[7:0]` with `[15:8]` zero, and read data is taken from `sub_rdata[7:0]`.
  - On a 16-bit bus, a byte access uses lane 01 for an even address and 10 for an odd one, with write data only on that lane and the other lane zero. Read data is taken from that lane.
  - Wider accesses on a 16-bit bus use lane 11.
- R8: `cpu_done` is a one-cycle pulse. It is raised in the cycle after the last sub-cycle is acknowledged. `cpu_ready` is 0 from acceptance until after that pulse.
- R9: A sub-cycle's request, address, lane and write data stay unchanged until `sub_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, accepted when `cpu_ready` is 1 |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_write | input | 1 | 1 write, 0 read |
| cpu_wdata | input | 32 | Write data, little-endian |
| cpu_ready | output | 1 | Idle and able to accept |
| cpu_done | output | 1 | Access finished (one cycle) |
| cpu_rdata | output | 32 | Assembled read data, valid with `cpu_done` |
| bus_wide | input | 1 | External bus width: 0 = 8 bits, 1 = 16 bits |
| sub_req | output | 1 | Sub-cycle request to the sequencer |
| sub_addr | output | ADDR_W | Bus-unit address of the sub-cycle |
| sub_write | output | 1 | Sub-cycle direction |
| sub_wdata | output | 16 | Sub-cycle write data |
| sub_lane | output | 2 | Active byte lanes |
| sub_hold_cs | output | 1 | Keep chip select asserted after this sub-cycle |
| sub_ack | input | 1 | Sequencer has completed the current sub-cycle |
| sub_rdata | input | 16 | Read data, valid with `sub_ack` |

## Verification
The assertions assume the following about the inputs:
- Halfword and word addresses are aligned.
- `sub_ack` is only raised while `sub_req` is high.
- `bus_wide` does not matter between acceptance and completion, because it is captured at acceptance.

The stimulus keeps within these rules. It issues only aligned accesses and waits for each completion before the next request. Its responder acknowledges only an open sub-cycle, after a latency of zero to two cycles that changes from access to access. On the 8-bit bus it drives the unused upper read byte with a constant nonzero value, so a lane selection error shows up in the read data.

// File: rtl/bus_width_splitter.sv
module bus_width_splitter #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_write,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [31:0]       cpu_rdata,
  input  logic              bus_wide,
  output logic              sub_req,
  output logic [ADDR_W-1:0] sub_addr,
  output logic              sub_write,
  output logic [15:0]       sub_wdata,
  output logic [1:0]        sub_lane,
  output logic              sub_hold_cs,
  input  logic              sub_ack,
  input  logic [15:0]       sub_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;

  state_t            st;
  logic [ADDR_W-1:0] base;
  logic [1:0]        size_q;
  logic              wr_q;
  logic              wide_q;
  logic [31:0]       wd_q;
  logic [1:0]        idx;
  logic [31:0]       acc;
  logic [1:0]        bytes_m1;
  logic [1:0]        last_idx;
  logic              is_last;
  logic [ADDR_W-1:0] byte_addr;

  assign bytes_m1  = (size_q == 2'd0) ? 2'd0 : (size_q == 2'd1) ? 2'd1 : 2'd3;
  assign last_idx  = wide_q ? {1'b0, bytes_m1[1]} : bytes_m1;
  assign is_last   = (idx == last_idx);
  assign byte_addr = base + (ADDR_W'(idx) << wide_q);

  assign cpu_ready   = (st == S_IDLE);
  assign cpu_done    = (st == S_DONE);
  assign cpu_rdata   = acc;
  assign sub_req     = (st == S_RUN);
  assign sub_addr    = wide_q ? (byte_addr >> 1) : byte_addr;
  assign sub_write   = wr_q;
  assign sub_hold_cs = wr_q && !is_last;

  always_comb begin
    if (!wide_q) begin
      sub_lane  = 2'b01;
      sub_wdata = {8'h00, wd_q[{idx, 3'b000} +: 8]};
    end else if (size_q == 2'd0) begin
      sub_lane  = base[0] ? 2'b10 : 2'b01;
      sub_wdata = base[0] ? {wd_q[7:0], 8'h00} : {8'h00, wd_q[7:0]};
    end else begin
      sub_lane  = 2'b11;
      sub_wdata = wd_q[{idx[0], 4'b0000} +: 16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base   <= '0;
      size_q <= '0;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      wd_q   <= '0;
      idx    <= '0;
      acc    <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_req) begin
          base   <= cpu_addr;
          size_q <= cpu_size;
          wr_q   <= cpu_write;
          wide_q <= bus_wide;
          wd_q   <= cpu_wdata;
          idx    <= '0;
          acc    <= '0;
          st     <= S_RUN;
        end
        S_RUN: if (sub_ack) begin
          if (!wr_q) begin
            if (!wide_q)
              acc[{idx, 3'b000} +: 8] <= sub_rdata[7:0];
            else if (size_q == 2'd0)
              acc[7:0] <= base[0] ? sub_rdata[15:8] : sub_rdata[7:0];
            else
              acc[{idx[0], 4'b0000} +: 16] <= sub_rdata;
          end
          if (is_last) st <= S_DONE;
          else         idx <= idx + 2'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !sub_req && !cpu_done);

  p_aligned_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready && cpu_size != 2'd0 |-> !cpu_addr[0]);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_req && sub_ack && !is_last |=> sub_req && sub_addr == $past(sub_addr) + 1'b1);

  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_req && sub_ack && sub_hold_cs |=> sub_req && sub_write);

  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_req && !sub_write |-> !sub_hold_cs);

  p_narrow_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_req && !wide_q |-> sub_lane == 2'b01 && sub_wdata[15:8] == 8'h00);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done && cpu_ready);

  p_req_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sub_req && !sub_ack |=> sub_req && $stable(sub_addr) && $stable(sub_lane) && $stable(sub_wdata));

endmodule

// File: tb/test_bus_width_splitter.sv
module test_bus_width_splitter;
  localparam int AW = 24;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          wr;
    logic [15:0]   wdata;
    logic [1:0]    lane;
    logic          hold;
  } sub_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_write = 1'b0, bus_wide = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [1:0] cpu_size = '0;
  logic [31:0] cpu_wdata = '0;
  logic cpu_ready, cpu_done, sub_req, sub_write, sub_hold_cs;
  logic [31:0] cpu_rdata;
  logic [AW-1:0] sub_addr;
  logic [15:0] sub_wdata;
  logic [1:0] sub_lane;
  logic sub_ack = 1'b0;
  logic [15:0] sub_rdata = '0;

  int tests = 0, fails = 0, lat = 0, cnt = 0, cycles = 0;
  bit fresh = 1'b1;
  logic [7:0] mem [256];
  sub_t exp_q [$];

  bus_width_splitter #(.ADDR_W(AW)) i_bus_width_splitter (
    .clk, .rst_n, .cpu_req, .cpu_addr, .cpu_size, .cpu_write, .cpu_wdata,
    .cpu_ready, .cpu_done, .cpu_rdata, .bus_wide,
    .sub_req, .sub_addr, .sub_write, .sub_wdata, .sub_lane, .sub_hold_cs,
    .sub_ack, .sub_rdata);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor and responder: compares each new sub-cycle against the scoreboard.
  always @(negedge clk) begin
    cycles++;
    sub_ack = 1'b0;
    if (!rst_n) begin
      fresh = 1'b1;
    end else if (sub_req) begin
      if (fresh) begin
        sub_t e;
        fresh = 1'b0;
        cnt = lat;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 extra sub-cycle", 64'(sub_addr), 64'h0);
        end else begin
          e = exp_q.pop_front();
          check(sub_addr == e.addr, "R3 sub address", 64'(sub_addr), 64'(e.addr));
          check(sub_write == e.wr, "R2 sub direction", 64'(sub_write), 64'(e.wr));
          check(sub_lane == e.lane, "R7 lane mask", 64'(sub_lane), 64'(e.lane));
          if (e.wr) check(sub_wdata == e.wdata, "R7 write data", 64'(sub_wdata), 64'(e.wdata));
          check(sub_hold_cs == e.hold, e.wr ? "R4 cs hold write" : "R5 cs release read",
                64'(sub_hold_cs), 64'(e.hold));
        end
      end
      if (cnt == 0) begin
        logic [7:0] a8;
        a8 = sub_addr[7:0];
        if (bus_wide) begin
          if (sub_write) begin
            if (sub_lane[0]) mem[{a8[6:0], 1'b0}] = sub_wdata[7:0];
            if (sub_lane[1]) mem[{a8[6:0], 1'b1}] = sub_wdata[15:8];
          end
          sub_rdata = {mem[{a8[6:0], 1'b1}], mem[{a8[6:0], 1'b0}]};
        end else begin
          if (sub_write) mem[a8] = sub_wdata[7:0];
          sub_rdata = {8'hEE, mem[a8]};
        end
        sub_ack = 1'b1;
        fresh = 1'b1;
      end else cnt--;
    end
  end

  task automatic access(input logic [1:0] size, input bit wr, input logic [AW-1:0] addr,
                        input logic [31:0] wdata, input string tag);
    int nb, unit, n;
    logic [31:0] exp_rd;
    nb = 1 << size;
    unit = bus_wide ? 2 : 1;
    n = (nb < unit) ? 1 : nb / unit;
    exp_rd = '0;
    for (int i = 0; i < nb; i++) exp_rd[8*i +: 8] = mem[8'(addr + AW'(i))];
    for (int i = 0; i < n; i++) begin
      sub_t e;
      logic [AW-1:0] ba;
      ba = addr + AW'(i * unit);
      e.addr = bus_wide ? (ba >> 1) : ba;
      e.wr = wr;
      e.hold = wr && (i != n - 1);
      if (!bus_wide) begin
        e.lane = 2'b01;
        e.wdata = {8'h00, wdata[8*i +: 8]};
      end else if (size == 2'd0) begin
        e.lane = addr[0] ? 2'b10 : 2'b01;
        e.wdata = addr[0] ? {wdata[7:0], 8'h00} : {8'h00, wdata[7:0]};
      end else begin
        e.lane = 2'b11;
        e.wdata = wdata[16*i +: 16];
      end
      exp_q.push_back(e);
    end
    @(negedge clk);
    cpu_req = 1'b1; cpu_size = size; cpu_write = wr; cpu_addr = addr; cpu_wdata = wdata;
    @(negedge clk);
    cpu_req = 1'b0;
    check(!cpu_ready, "R8 busy after accept", 64'(cpu_ready), 64'h0);
    while (!cpu_done) @(negedge clk);
    check(exp_q.size() == 0, {"R2 sub-cycle count before done ", tag}, 64'(exp_q.size()), 64'h0);
    if (!wr) check(cpu_rdata == exp_rd, {"R6 assembled read ", tag}, 64'(cpu_rdata), 64'(exp_rd));
    @(negedge clk);
    check(!cpu_done && cpu_ready, "R8 single done pulse", {62'h0, cpu_done, cpu_ready}, 64'h1);
    exp_q.delete();
    lat = (lat + 1) % 3;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    check(cpu_ready && !sub_req && !cpu_done, "R1 reset state",
          {61'h0, cpu_ready, sub_req, cpu_done}, 64'h4);
    rst_n = 1'b1;

    bus_wide = 1'b0;
    access(2'd2, 1'b1, 24'h10, 32'hA1B2C3D4, "R2 narrow word write");
    access(2'd2, 1'b0, 24'h10, '0, "R6 narrow word read");
    access(2'd1, 1'b0, 24'h12, '0, "R6 narrow half read");
    access(2'd0, 1'b0, 24'h13, '0, "R7 narrow byte read");
    access(2'd1, 1'b1, 24'h20, 32'h00005A6B, "R4 narrow half write");
    access(2'd0, 1'b1, 24'h23, 32'h0000007E, "R4 narrow byte write");
    access(2'd2, 1'b0, 24'h20, '0, "R6 narrow readback");

    bus_wide = 1'b1;
    access(2'd2, 1'b1, 24'h40, 32'h11223344, "R2 wide word write");
    access(2'd2, 1'b0, 24'h40, '0, "R6 wide word read");
    access(2'd1, 1'b0, 24'h42, '0, "R3 wide half read");
    access(2'd0, 1'b0, 24'h41, '0, "R7 wide odd byte read");
    access(2'd0, 1'b0, 24'h40, '0, "R7 wide even byte read");
    access(2'd0, 1'b1, 24'h45, 32'h000000C9, "R7 wide odd byte write");
    access(2'd0, 1'b1, 24'h46, 32'h000000D8, "R7 wide even byte write");
    access(2'd1, 1'b1, 24'h48, 32'h0000BEEF, "R4 wide half write");
    access(2'd2, 1'b0, 24'h44, '0, "R6 wide readback");
    access(2'd2, 1'b0, 24'h48, '0, "R6 wide half readback");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule